// File: doc/BRIEF.md
# Handshaked Polled Input Port

This block takes words from a peripheral that runs on its own timing and hands them to a processor that polls for them. The peripheral uses a two-wire handshake. It puts a word on its data bus and raises a valid line. The port captures the word into a buffer, sets a full flag and raises an accepted line. The peripheral then drops valid.

The port keeps the accepted line high until the processor has taken the word. The release of the handshake is therefore tied to the processor clearing the full flag, and the peripheral is paced by the polling loop. The valid line is brought into the port clock through a two-flop synchroniser. The bus is sampled one cycle after the synchronised valid is first seen high, which gives the data time to settle.

On the processor side, the port answers only its own device address. Two function codes are decoded: a status read and a data read. The response is registered and is presented for one cycle together with an output-enable. When the port is not answering, its read-data lines are held at zero.

Top module: `poll_rx_port`

## Requirements
- R1: After reset, `dev_ack` is 0, `cpu_rd_oe` is 0 and `cpu_rdata` is 0, and a status read returns a full flag of 0.
- R2: While the port is idle, a word held on `dev_data` with `dev_valid` high is captured into the buffer. The full flag is then set and `dev_ack` rises.
- R3: While the full flag is 1, `dev_ack` stays high, even after `dev_valid` has fallen.
- R4: A read strobe with the device address and function code 2'b01 returns the status. The full flag is in bit 0 and all other bits are 0. A status read never changes the flag.
- R5: A read strobe with the device address and function code 2'b10 returns the buffered word and clears the full flag on the same clock edge.
- R6: Once the full flag is clear and `dev_valid` has been seen low since the capture, `dev_ack` falls. The port then accepts the next word.
- R7: A read strobe whose address differs from `DEV_ID` gives no response (`cpu_rd_oe` 0, `cpu_rdata` 0) and leaves the full flag unchanged.
- R8: A read strobe with the device address and function code 2'b00 or 2'b11 gives no response and changes nothing.
- R9: If `dev_valid` rises again while the full flag is still 1, the new word is not captured before the handshake has returned to idle. The buffered word stays intact until the processor reads it.
- R10: A read response appears on the clock edge that samples the strobe and lasts exactly one cycle. Otherwise `cpu_rd_oe` is 0 and `cpu_rdata` is 0.
- R11: A data read while the full flag is 0 returns the last captured word and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_data | input | DW | Peripheral data bus |
| dev_valid | input | 1 | Peripheral data-valid, asynchronous |
| dev_ack | output | 1 | Data-accepted back to the peripheral |
| cpu_addr | input | AW | Device address from the processor |
| cpu_func | input | 2 | Function code: 01 status, 10 data |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | DW | Registered read data, zero when not answering |
| cpu_rd_oe | output | 1 | High for the cycle in which `cpu_rdata` is driven |

## Verification
The bench builds the port with DW=8, AW=4 and DEV_ID=4'hA. At these values the all-zero and all-one words and the alternating bit patterns can be sent through the buffer. Near-miss addresses such as 4'hB can be tried against the decoder. Using a narrow word keeps the status layout (flag in bit 0, zeros above) easy to predict. The two-stage synchroniser keeps the capture latency short, so the early-valid case of R9 can be set up within a few cycles.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_SETTLE = 2'd1,
        HS_HOLD   = 2'd2
    } hs_state_e;

    localparam logic [1:0] FN_STATUS = 2'b01;
    localparam logic [1:0] FN_DATA   = 2'b10;
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_r_t;

    sync_r_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.chain[STAGES-1];
endmodule

// File: rtl/hpi_hs_fsm.sv
module hpi_hs_fsm
    import hpi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_s,
    input  logic [DW-1:0] bus_data,
    input  logic          f_clr,
    output logic          ack,
    output logic          full,
    output logic [DW-1:0] word
);
    typedef struct packed {
        hs_state_e     state;
        logic          ack;
        logic          full;
        logic          seen_low;
        logic [DW-1:0] word;
    } hs_r_t;

    hs_r_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (f_clr) r_d.full = 1'b0;
        case (r_q.state)
            HS_IDLE: begin
                if (valid_s) r_d.state = HS_SETTLE;
            end
            HS_SETTLE: begin
                r_d.word     = bus_data;
                r_d.full     = 1'b1;
                r_d.ack      = 1'b1;
                r_d.seen_low = 1'b0;
                r_d.state    = HS_HOLD;
            end
            HS_HOLD: begin
                if (!valid_s) r_d.seen_low = 1'b1;
                if (!r_q.full && r_q.seen_low) begin
                    r_d.ack   = 1'b0;
                    r_d.state = HS_IDLE;
                end
            end
            default: r_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= HS_IDLE;
            r_q.ack      <= 1'b0;
            r_q.full     <= 1'b0;
            r_q.seen_low <= 1'b0;
            r_q.word     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack  = r_q.ack;
    assign full = r_q.full;
    assign word = r_q.word;
endmodule

// File: rtl/hpi_cpu_port.sv
module hpi_cpu_port
    import hpi_pkg::*;
#(
    parameter int             DW     = 8,
    parameter int             AW     = 4,
    parameter logic [AW-1:0]  DEV_ID = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    func,
    input  logic          rd,
    input  logic          full,
    input  logic [DW-1:0] word,
    output logic          f_clr,
    output logic [DW-1:0] rdata,
    output logic          oe
);
    typedef struct packed {
        logic          oe;
        logic [DW-1:0] rdata;
    } port_r_t;

    port_r_t r_q, r_d;
    logic    hit;

    assign hit   = rd && (addr == DEV_ID);
    assign f_clr = hit && (func == FN_DATA);

    always_comb begin
        r_d.oe    = 1'b0;
        r_d.rdata = '0;
        if (hit && func == FN_STATUS) begin
            r_d.oe    = 1'b1;
            r_d.rdata = {{(DW-1){1'b0}}, full};
        end else if (hit && func == FN_DATA) begin
            r_d.oe    = 1'b1;
            r_d.rdata = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign oe    = r_q.oe;
endmodule

// File: rtl/poll_rx_port.sv
module poll_rx_port #(
    parameter int            DW          = 8,
    parameter int            AW          = 4,
    parameter logic [AW-1:0] DEV_ID      = 4'hA,
    parameter int            SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dev_data,
    input  logic          dev_valid,
    output logic          dev_ack,
    input  logic [AW-1:0] cpu_addr,
    input  logic [1:0]    cpu_func,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rd_oe
);
    logic          valid_s;
    logic          f_clr;
    logic          full_w;
    logic [DW-1:0] word_w;

    hpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dev_valid),
        .q     (valid_s)
    );

    hpi_hs_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_s  (valid_s),
        .bus_data (dev_data),
        .f_clr    (f_clr),
        .ack      (dev_ack),
        .full     (full_w),
        .word     (word_w)
    );

    hpi_cpu_port #(.DW(DW), .AW(AW), .DEV_ID(DEV_ID)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cpu_addr),
        .func  (cpu_func),
        .rd    (cpu_rd),
        .full  (full_w),
        .word  (word_w),
        .f_clr (f_clr),
        .rdata (cpu_rdata),
        .oe    (cpu_rd_oe)
    );
endmodule

// File: rtl/hpi_chk.sv
module hpi_chk #(
    parameter int            DW     = 8,
    parameter int            AW     = 4,
    parameter logic [AW-1:0] DEV_ID = 4'hA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_ack,
    input logic          full,
    input logic [DW-1:0] word,
    input logic          cpu_rd,
    input logic [AW-1:0] cpu_addr,
    input logic [1:0]    cpu_func,
    input logic          rd_oe,
    input logic [DW-1:0] rdata
);
    // R3
    full_holds_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> dev_ack);

    // R6
    ack_fall_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ack) |-> !full);

    // R9
    word_kept_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && $past(full)) |-> $stable(word));

    // R4
    status_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_rd && cpu_addr == DEV_ID && cpu_func == 2'b01 && full) |-> full);

    // R7
    oe_needs_address_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(cpu_rd && cpu_addr == DEV_ID));

    // R10
    quiet_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rdata == '0));
endmodule

bind poll_rx_port hpi_chk #(.DW(DW), .AW(AW), .DEV_ID(DEV_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_ack  (dev_ack),
    .full     (full_w),
    .word     (word_w),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .cpu_func (cpu_func),
    .rd_oe    (cpu_rd_oe),
    .rdata    (cpu_rdata)
);

// File: tb/tb_poll_rx_port.sv
module tb_poll_rx_port;
    localparam int            DW     = 8;
    localparam int            AW     = 4;
    localparam logic [AW-1:0] DEV_ID = 4'hA;
    localparam time           CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] dev_data = '0;
    logic          dev_valid = 1'b0;
    logic          dev_ack;
    logic [AW-1:0] cpu_addr = '0;
    logic [1:0]    cpu_func = 2'b00;
    logic          cpu_rd = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rd_oe;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_rx_port #(.DW(DW), .AW(AW), .DEV_ID(DEV_ID)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_data  (dev_data),
        .dev_valid (dev_valid),
        .dev_ack   (dev_ack),
        .cpu_addr  (cpu_addr),
        .cpu_func  (cpu_func),
        .cpu_rd    (cpu_rd),
        .cpu_rdata (cpu_rdata),
        .cpu_rd_oe (cpu_rd_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one bus read; returns the response seen one cycle after the strobe
    task automatic bus_rd(input logic [AW-1:0] a, input logic [1:0] f,
                          output logic oe, output logic [DW-1:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_func = f; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        oe = cpu_rd_oe; d = cpu_rdata;
    endtask

    task automatic wait_ack(input logic lvl, input int limit, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (dev_ack == lvl) begin ok = 1'b1; break; end
        end
    endtask

    // driver: pushes expected word, runs full handshake
    task automatic dev_send(input logic [DW-1:0] w);
        bit ok;
        exp_q.push_back(w);
        @(negedge clk);
        dev_data = w; dev_valid = 1'b1;
        wait_ack(1'b1, 2000, ok);
        check(ok, "R2 ack rise", dev_ack, 1);
        dev_valid = 1'b0;
        wait_ack(1'b0, 4000, ok);
        check(ok, "R6 ack fall", dev_ack, 0);
    endtask

    // monitor: poll status, read word, compare with scoreboard
    task automatic cpu_take();
        logic oe; logic [DW-1:0] d; logic [DW-1:0] e;
        for (int i = 0; i < 500; i++) begin
            bus_rd(DEV_ID, 2'b01, oe, d);
            if (d[0]) break;
        end
        bus_rd(DEV_ID, 2'b10, oe, d);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        check(oe && d == e, "R5 data word", d, e);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic oe; logic [DW-1:0] d; bit ok;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dev_ack == 0 && cpu_rd_oe == 0 && cpu_rdata == 0, "R1 reset", {dev_ack, cpu_rd_oe}, 0);
        rst_n = 1'b1;
        bus_rd(DEV_ID, 2'b01, oe, d);
        check(oe && d == 8'h00, "R1 flag clear", d, 0);
        // R10 response lasts one cycle
        @(negedge clk);
        check(cpu_rd_oe == 0 && cpu_rdata == 0, "R10 one cycle", cpu_rd_oe, 0);
        // R11 data read with empty buffer
        bus_rd(DEV_ID, 2'b10, oe, d);
        check(oe && d == 8'h00, "R11 empty read", d, 0);

        // R2/R3: send a word, hold CPU off
        @(negedge clk);
        dev_data = 8'h3C; dev_valid = 1'b1;
        wait_ack(1'b1, 50, ok);
        check(ok, "R2 capture ack", dev_ack, 1);
        dev_valid = 1'b0; dev_data = 8'hFF;
        repeat (20) @(negedge clk);
        check(dev_ack == 1, "R3 ack held", dev_ack, 1);
        // R4 status twice, flag stays
        bus_rd(DEV_ID, 2'b01, oe, d);
        check(oe && d == 8'h01, "R4 status full", d, 1);
        bus_rd(DEV_ID, 2'b01, oe, d);
        check(oe && d == 8'h01, "R4 status repeat", d, 1);
        // R7 wrong address
        bus_rd(4'hB, 2'b10, oe, d);
        check(!oe && d == 0, "R7 other address", oe, 0);
        // R8 undefined codes
        bus_rd(DEV_ID, 2'b11, oe, d);
        check(!oe && d == 0, "R8 code 11", oe, 0);
        bus_rd(DEV_ID, 2'b00, oe, d);
        check(!oe && d == 0, "R8 code 00", oe, 0);
        bus_rd(DEV_ID, 2'b01, oe, d);
        check(d == 8'h01, "R7 R8 flag intact", d, 1);
        // R5 data read clears flag
        bus_rd(DEV_ID, 2'b10, oe, d);
        check(oe && d == 8'h3C, "R5 word", d, 8'h3C);
        bus_rd(DEV_ID, 2'b01, oe, d);
        check(d == 8'h00, "R5 flag cleared", d, 0);
        wait_ack(1'b0, 20, ok);
        check(ok, "R6 ack drops", dev_ack, 0);
        // R11 re-read empty returns last word
        bus_rd(DEV_ID, 2'b10, oe, d);
        check(oe && d == 8'h3C, "R11 last word", d, 8'h3C);

        // R9 early valid while full
        @(negedge clk);
        dev_data = 8'h11; dev_valid = 1'b1;
        wait_ack(1'b1, 50, ok);
        dev_valid = 1'b0;
        repeat (6) @(negedge clk);
        dev_data = 8'h22; dev_valid = 1'b1;
        repeat (12) @(negedge clk);
        bus_rd(DEV_ID, 2'b10, oe, d);
        check(oe && d == 8'h11, "R9 first word kept", d, 8'h11);
        for (int i = 0; i < 50; i++) begin
            bus_rd(DEV_ID, 2'b01, oe, d);
            if (d[0]) break;
        end
        check(d == 8'h01, "R9 second captured", d, 1);
        bus_rd(DEV_ID, 2'b10, oe, d);
        check(oe && d == 8'h22, "R9 second word", d, 8'h22);
        dev_valid = 1'b0;
        wait_ack(1'b0, 50, ok);
        check(ok, "R6 idle after R9", dev_ack, 0);

        // scoreboard stream
        fork
            begin
                dev_send(8'h00); dev_send(8'hFF); dev_send(8'hA5);
                dev_send(8'h5A); dev_send(8'h01); dev_send(8'h80);
            end
            begin
                for (int k = 0; k < 6; k++) begin
                    repeat (k * 3) @(negedge clk);
                    cpu_take();
                end
            end
        join
        check(exp_q.size() == 0, "R2 all consumed", exp_q.size(), 0);
        summary();
    end
endmodule